// File: doc/BRIEF.md
# Sample-Queued Dimming Pulse-Width Modulator

This block drives a dimming output, such as an LED backlight, with a pulse-width modulated signal. A free-running counter sets the period length. Duty values are never written straight into the comparator. Software pushes them into a small sample queue, and the modulator takes the next entry only when a period ends. Because of this, a duty change cannot cut a period short or stretch it. No active or inactive phase is ever dropped or merged with its neighbour, even when the queue was empty at the moment of the write.

Each queued sample can be replayed for 1, 2, 4 or 8 whole periods before the next one is taken. When the queue runs dry, the last applied duty stays in force. A single register-style write port loads samples, the period, the repeat setting and the output polarity. A separate enable starts the modulator, and clearing it stops and clears the modulator.

Top module: `dimmer_pwm`

## Requirements
- R1: A duty sample changes the output only from the first period that starts after the sample is taken from the queue. The applied duty stays constant within a period, and this holds even when the sample was written into an empty queue partway through a period.
- R2: The repeat setting (`wr_data[1:0]` written with `wr_sel` = 2) selects how many consecutive periods each sample is used before the next pop: 0 gives 1, 1 gives 2, 2 gives 4, 3 gives 8. The setting is captured when the sample is popped.
- R3: When the queue is empty at a period boundary, the modulator keeps the duty it last applied.
- R4: The queue holds 4 samples and reports `fifo_empty` and `fifo_full`. A sample write while the queue is full is dropped, even if a pop happens in the same cycle. Such a write sets `fifo_overflow`, which stays set until the block is disabled.
- R5: A duty of 0 keeps the output at its inactive level for the whole period. A duty equal to or greater than the period value keeps it at the active level for the whole period.
- R6: The counter runs from 0 to the period value and then wraps to 0, so one period lasts period+1 clocks. A new period value (`wr_sel` = 1) takes effect only at the next wrap.
- R7: With polarity 0 (`wr_data[0]` written with `wr_sel` = 3), the output is high from the wrap until the counter reaches the duty, and low after that. Polarity 1 inverts this. The output is registered, so it shows the counter state of the previous clock.
- R8: While `enable` is low, the counter is held at 0, the queue is emptied, the overflow flag is cleared, the applied duty returns to 0, and the output sits at its inactive level. Sample writes are ignored while `enable` is low. Settings writes still land.
- R9: `wr_sel` chooses the target of a write: 0 pushes a sample, 1 sets the period, 2 sets the repeat code and 3 sets the polarity. All settings reset to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Run the modulator; low stops and clears it |
| wr_en | input | 1 | Write strobe for the register port |
| wr_sel | input | 2 | Write target: sample, period, repeat, polarity |
| wr_data | input | W | Write data |
| pwm_out | output | 1 | Modulated output |
| fifo_empty | output | 1 | Sample queue holds no entries |
| fifo_full | output | 1 | Sample queue holds 4 entries |
| fifo_overflow | output | 1 | Sticky flag for a sample write dropped while the queue was full |

## Verification
The assertions assume that `enable` and the write port are synchronous to `clk`, and that the period register is never changed in a way that moves a running counter past its end. The second assumption holds because the period is latched only at the wrap. The stimulus drives every input on the falling edge. It keeps the period between 0 and 12 so that many wraps occur. It writes duties up to a little past the period, so both saturation ends are reached. Occasional short disables exercise the clear path. A reference model checks every clock.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

   typedef enum logic [1:0] {
      SEL_SAMPLE   = 2'd0,
      SEL_PERIOD   = 2'd1,
      SEL_REPEAT   = 2'd2,
      SEL_POLARITY = 2'd3
   } pwm_sel_e;

   localparam int REP_CODE_W = 2;
   localparam int REP_LEFT_W = 3;

   // Periods per sample minus one, from the two-bit repeat code.
   function automatic logic [REP_LEFT_W-1:0] rep_reload(input logic [REP_CODE_W-1:0] code);
      logic [REP_LEFT_W:0] n;
      n = (REP_LEFT_W+1)'(1) << code;
      return REP_LEFT_W'(n - 1'b1);
   endfunction

endpackage

// File: rtl/pwm_cfg_regs.sv
module pwm_cfg_regs
   import pwm_pkg::*;
#(
   parameter int W = 16
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_en,
   input  logic [1:0]            wr_sel,
   input  logic [W-1:0]          wr_data,
   output logic [W-1:0]          period_o,
   output logic [REP_CODE_W-1:0] rep_code_o,
   output logic                  pol_o,
   output logic                  sample_wr_o
);

   pwm_sel_e sel;
   assign sel = pwm_sel_e'(wr_sel);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         period_o   <= '0;
         rep_code_o <= '0;
         pol_o      <= 1'b0;
      end else if (wr_en) begin
         case (sel)
            SEL_PERIOD:   period_o   <= wr_data;
            SEL_REPEAT:   rep_code_o <= wr_data[REP_CODE_W-1:0];
            SEL_POLARITY: pol_o      <= wr_data[0];
            default: ;
         endcase
      end
   end

   assign sample_wr_o = wr_en && (sel == SEL_SAMPLE);

   assert_period_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel == 2'd1) |=> (period_o == $past(wr_data)));

endmodule

// File: rtl/pwm_sample_fifo.sv
module pwm_sample_fifo #(
   parameter int W     = 16,
   parameter int DEPTH = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         flush,
   input  logic         push,
   input  logic [W-1:0] push_data,
   input  logic         pop,
   output logic [W-1:0] head,
   output logic         empty,
   output logic         full,
   output logic         overflow
);

   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CW = $clog2(DEPTH + 1);

   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("pwm_sample_fifo: DEPTH must be a power of two, at least 2");
      end
   endgenerate

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wp_q, rp_q;
   logic [CW-1:0] count_q;
   logic          do_push, do_pop;

   assign empty   = (count_q == '0);
   assign full    = (count_q == CW'(DEPTH));
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign head    = mem[rp_q];

   for (genvar g = 0; g < DEPTH; g++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            mem[g] <= '0;
         else if (!flush && do_push && wp_q == AW'(g))
            mem[g] <= push_data;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp_q     <= '0;
         rp_q     <= '0;
         count_q  <= '0;
         overflow <= 1'b0;
      end else if (flush) begin
         wp_q     <= '0;
         rp_q     <= '0;
         count_q  <= '0;
         overflow <= 1'b0;
      end else begin
         if (do_push) wp_q <= wp_q + 1'b1;
         if (do_pop)  rp_q <= rp_q + 1'b1;
         count_q <= count_q + CW'(do_push) - CW'(do_pop);
         if (push && full) overflow <= 1'b1;
      end
   end

   assert_full_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (push && full && !pop && !flush) |=> full);
   assert_ovf_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (overflow && !flush) |=> overflow);
   assert_flags_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !(full && empty));
   assert_flush_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (empty && !overflow));
   assert_no_pop_empty_R3: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> !empty);

endmodule

// File: rtl/pwm_period_engine.sv
module pwm_period_engine
   import pwm_pkg::*;
#(
   parameter int W = 16
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  en,
   input  logic [W-1:0]          period,
   input  logic [REP_CODE_W-1:0] rep_code,
   input  logic                  pol,
   input  logic                  fifo_empty,
   input  logic [W-1:0]          fifo_head,
   output logic                  pop,
   output logic                  pwm_out
);

   generate
      if (W < 2) begin : g_bad_width
         $error("pwm_period_engine: W must be at least 2");
      end
   endgenerate

   logic [W-1:0]          cnt_q, per_q, duty_q;
   logic [REP_LEFT_W-1:0] rep_q;
   logic                  rollover, active;

   assign rollover = (cnt_q == per_q);
   assign pop      = en && rollover && (rep_q == '0) && !fifo_empty;
   assign active   = (duty_q != '0) && ((duty_q >= per_q) || (cnt_q < duty_q));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         per_q   <= '0;
         duty_q  <= '0;
         rep_q   <= '0;
         pwm_out <= 1'b0;
      end else if (!en) begin
         cnt_q   <= '0;
         per_q   <= period;
         duty_q  <= '0;
         rep_q   <= '0;
         pwm_out <= pol;
      end else begin
         pwm_out <= active ^ pol;
         if (rollover) begin
            cnt_q <= '0;
            per_q <= period;
            if (pop) begin
               duty_q <= fifo_head;
               rep_q  <= rep_reload(rep_code);
            end else if (rep_q != '0) begin
               rep_q <= rep_q - 1'b1;
            end
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   assert_duty_at_boundary_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !rollover) |=> $stable(duty_q));
   assert_repeat_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
      pop |=> (rep_q == rep_reload($past(rep_code))));
   assert_hold_last_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (en && rollover && fifo_empty) |=> $stable(duty_q));
   assert_count_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
      en |-> (cnt_q <= per_q));
   assert_period_at_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !rollover) |=> $stable(per_q));
   assert_idle_level_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (pwm_out == $past(pol)));

endmodule

// File: rtl/dimmer_pwm.sv
module dimmer_pwm
   import pwm_pkg::*;
#(
   parameter int W     = 16,
   parameter int DEPTH = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         enable,
   input  logic         wr_en,
   input  logic [1:0]   wr_sel,
   input  logic [W-1:0] wr_data,
   output logic         pwm_out,
   output logic         fifo_empty,
   output logic         fifo_full,
   output logic         fifo_overflow
);

   logic [W-1:0]          period;
   logic [REP_CODE_W-1:0] rep_code;
   logic                  pol, sample_wr, pop;
   logic [W-1:0]          head;

   pwm_cfg_regs #(.W(W)) i_regs (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_en       (wr_en),
      .wr_sel      (wr_sel),
      .wr_data     (wr_data),
      .period_o    (period),
      .rep_code_o  (rep_code),
      .pol_o       (pol),
      .sample_wr_o (sample_wr)
   );

   pwm_sample_fifo #(.W(W), .DEPTH(DEPTH)) i_fifo (
      .clk       (clk),
      .rst_n     (rst_n),
      .flush     (!enable),
      .push      (sample_wr && enable),
      .push_data (wr_data),
      .pop       (pop),
      .head      (head),
      .empty     (fifo_empty),
      .full      (fifo_full),
      .overflow  (fifo_overflow)
   );

   pwm_period_engine #(.W(W)) i_engine (
      .clk        (clk),
      .rst_n      (rst_n),
      .en         (enable),
      .period     (period),
      .rep_code   (rep_code),
      .pol        (pol),
      .fifo_empty (fifo_empty),
      .fifo_head  (head),
      .pop        (pop),
      .pwm_out    (pwm_out)
   );

endmodule

// File: tb/test_dimmer_pwm.sv
module test_dimmer_pwm;

   localparam int W = 16;
   localparam int DEPTH = 4;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         enable = 1'b0;
   logic         wr_en = 1'b0;
   logic [1:0]   wr_sel = 2'd0;
   logic [W-1:0] wr_data = '0;
   logic         pwm_out, fifo_empty, fifo_full, fifo_overflow;

   int n_checks = 0;
   int n_fail = 0;
   bit done = 1'b0;
   string cur_req = "R8";

   always #10 clk = ~clk;

   dimmer_pwm #(.W(W), .DEPTH(DEPTH)) i_dimmer_pwm (
      .clk(clk), .rst_n(rst_n), .enable(enable), .wr_en(wr_en),
      .wr_sel(wr_sel), .wr_data(wr_data), .pwm_out(pwm_out),
      .fifo_empty(fifo_empty), .fifo_full(fifo_full), .fifo_overflow(fifo_overflow)
   );

   // Reference model built from the requirements.
   int m_cnt, m_per_act, m_per_reg, m_duty, m_rep, m_rsel, m_pol, m_n, m_ovf, m_pwm;
   int m_q [DEPTH];

   function automatic int active_level(int duty, int per, int cnt);
      return (duty != 0 && (duty >= per || cnt < duty)) ? 1 : 0;
   endfunction

   function automatic int periods_of(int code);
      return 1 << code;
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_cnt = 0; m_per_act = 0; m_per_reg = 0; m_duty = 0; m_rep = 0;
         m_rsel = 0; m_pol = 0; m_n = 0; m_ovf = 0; m_pwm = 0;
      end else begin
         if (!enable) begin
            m_pwm = m_pol; m_cnt = 0; m_duty = 0; m_rep = 0;
            m_per_act = m_per_reg; m_n = 0; m_ovf = 0;
         end else begin
            bit was_full;
            was_full = (m_n == DEPTH);
            m_pwm = active_level(m_duty, m_per_act, m_cnt) ^ m_pol;
            if (m_cnt == m_per_act) begin
               m_cnt = 0;
               m_per_act = m_per_reg;
               if (m_rep == 0 && m_n > 0) begin
                  m_duty = m_q[0];
                  for (int i = 0; i < DEPTH - 1; i++) m_q[i] = m_q[i+1];
                  m_n--;
                  m_rep = periods_of(m_rsel) - 1;
               end else if (m_rep > 0) begin
                  m_rep--;
               end
            end else begin
               m_cnt++;
            end
            if (wr_en && wr_sel == 2'd0) begin
               if (was_full) m_ovf = 1;
               else begin m_q[m_n] = int'(wr_data); m_n++; end
            end
         end
         if (wr_en) begin
            case (wr_sel)
               2'd1: m_per_reg = int'(wr_data);
               2'd2: m_rsel = int'(wr_data[1:0]);
               2'd3: m_pol = int'(wr_data[0]);
               default: ;
            endcase
         end
      end
   end

   task automatic check(string req, string what, int act, int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
      end
   endtask

   task automatic tick();
      @(negedge clk);
      check(cur_req, "pwm_out", int'(pwm_out), m_pwm);
      check("R4", "fifo_empty", int'(fifo_empty), (m_n == 0) ? 1 : 0);
      check("R4", "fifo_full", int'(fifo_full), (m_n == DEPTH) ? 1 : 0);
      check("R4", "fifo_overflow", int'(fifo_overflow), m_ovf);
   endtask

   task automatic run(int n);
      for (int i = 0; i < n; i++) tick();
   endtask

   task automatic wr(int sel, int data);
      wr_en = 1'b1; wr_sel = 2'(sel); wr_data = W'(data);
      tick();
      wr_en = 1'b0;
   endtask

   initial begin : watchdog
      repeat (190000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog expired");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
         $finish;
      end
   end

   initial begin : stim
      int per;
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      // R8: reset state
      check("R8", "pwm_out reset", int'(pwm_out), 0);
      check("R4", "empty reset", int'(fifo_empty), 1);
      rst_n = 1'b1;
      run(3);

      cur_req = "R9";
      wr(1, 9); wr(2, 0); wr(3, 0);
      enable = 1'b1;
      run(5);

      cur_req = "R5";
      wr(0, 0); wr(0, 9); wr(0, 12); wr(0, 4);
      run(60);

      cur_req = "R3";
      run(30);

      cur_req = "R1";
      run(13);
      wr(0, 7);         // queue empty, written mid-period
      run(35);

      cur_req = "R2";
      foreach (m_q[k]) begin end
      for (int code = 3; code >= 1; code--) begin
         wr(2, code);
         wr(0, 2); wr(0, 8);
         run(10 * periods_of(code) * 2 + 10);
      end

      cur_req = "R4";
      wr(2, 3);
      for (int i = 0; i < 6; i++) wr(0, i + 1);
      check("R4", "full after 6 writes", int'(fifo_full), 1);
      check("R4", "overflow after 6 writes", int'(fifo_overflow), 1);
      run(400);

      cur_req = "R6";
      wr(2, 0);
      wr(1, 4); wr(0, 2); run(40);
      wr(1, 0); wr(0, 1); run(10);
      wr(1, 9); wr(0, 5); run(30);

      cur_req = "R7";
      wr(3, 1); wr(0, 3); wr(0, 6); run(50);
      wr(3, 0); run(30);

      cur_req = "R8";
      enable = 1'b0;
      wr(0, 5); wr(3, 1);
      run(4);
      check("R8", "empty while disabled", int'(fifo_empty), 1);
      enable = 1'b1;
      run(30);
      wr(3, 0); wr(0, 3); run(30);

      cur_req = "R1";
      per = 9;
      for (int i = 0; i < 5000; i++) begin
         int r;
         r = $urandom % 100;
         if (r < 12) wr(0, $urandom % (per + 3));
         else if (r < 14) wr(2, $urandom % 4);
         else if (r < 15) begin per = $urandom % 13; wr(1, per); end
         else if (r < 16) wr(3, $urandom % 2);
         else if (r < 17) begin
            enable = 1'b0; run(1 + $urandom % 3); enable = 1'b1;
         end else tick();
      end

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
   end

endmodule